// File: doc/BRIEF.md
# Pipeline Run, Halt and Sleep Controller

This block decides, cycle by cycle, whether a processor pipeline may advance. It watches debug requests, break lines, a sleep-instruction strobe, the state of external accesses and pipeline drain, a fault strobe and a two-bit wake input. From these it holds one of five states: RUN, DRAIN, SLEEP, DBG_HALT and ERR_HALT. It drives a stall enable plus flags that tell the surrounding logic why the pipeline is stopped.

A sleep instruction does not put the core to sleep at once. The block first waits in DRAIN until no external access is outstanding and the pipeline reports it is empty. A wake input then returns the block from SLEEP to RUN. The debug stop line arrives from a slower clock domain. It is synchronised in two flops and acts only on its rising edge. Two parameters remove the debug features and the fault-tolerance feature.

State transitions, in priority order within each state:
- RUN: fault → ERR_HALT; halt request or debug halt command → DBG_HALT; sleep strobe → DRAIN.
- DRAIN: fault → ERR_HALT; halt request or debug halt command → DBG_HALT; accesses idle and pipeline drained → SLEEP.
- SLEEP: fault → ERR_HALT; halt request → DBG_HALT; any wake bit → RUN.
- DBG_HALT: fault → ERR_HALT; resume → RUN.
- ERR_HALT: left only through reset.

Top module: `halt_sleep_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. One cycle of it puts the block in RUN, with every output low.
- R2: `dbg_stop_i` passes through a two-flop synchroniser and an edge detector. The block enters DBG_HALT at the third rising clock edge after the input rises. A level held high gives exactly one halt.
- R3: With DEBUG_EN = 0, the inputs `dbg_stop_i`, `dbg_halt_cmd_i`, `dbg_resume_i`, `brk_i` and `nm_brk_i` have no effect.
- R4: `dbg_halt_cmd_i` moves RUN or DRAIN to DBG_HALT at the next edge. In SLEEP it does not move the state. Instead, `dbg_wake_req_o` goes high in the same cycle.
- R5: `sleep_exec_i` in RUN moves the block to DRAIN. DRAIN moves to SLEEP only at an edge where `ext_busy_i` is 0 and `pipe_drained_i` is 1. RUN never goes straight to SLEEP.
- R6: In SLEEP, `wake_i` with either bit at 1 returns the block to RUN. In every other state `wake_i` is ignored.
- R7: With FAULT_TOL = 1, `miss_exc_i` sends any state to ERR_HALT, ahead of every other request. ERR_HALT is left only by reset. With FAULT_TOL = 0, `miss_exc_i` is ignored.
- R8: `nm_brk_i` halts from RUN, DRAIN or SLEEP whatever the mask. `brk_i` halts only while `brk_mask_i` is 0.
- R9: `dbg_resume_i` moves DBG_HALT to RUN.
- R10: Outputs follow the state. `stall_o` is high in all states except RUN. `halted_o` is high in DBG_HALT and ERR_HALT. `sleeping_o` is high only in SLEEP. `err_halt_o` is high only in ERR_HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_stop_i | input | 1 | Debug stop from slow debug domain, edge acting |
| dbg_halt_cmd_i | input | 1 | Halt command from debug interface |
| dbg_resume_i | input | 1 | Resume strobe from debug interface |
| brk_i | input | 1 | Maskable break |
| nm_brk_i | input | 1 | Non-maskable break |
| brk_mask_i | input | 1 | Masks `brk_i` when high |
| sleep_exec_i | input | 1 | Sleep instruction executed |
| ext_busy_i | input | 1 | External access outstanding |
| pipe_drained_i | input | 1 | Pipeline empty |
| miss_exc_i | input | 1 | Missed-exception fault strobe |
| wake_i | input | 2 | Wake request bits |
| halted_o | output | 1 | Pipeline halted (debug or error) |
| sleeping_o | output | 1 | Block is asleep |
| err_halt_o | output | 1 | Halted by fault |
| dbg_wake_req_o | output | 1 | Asks external logic to wake the block |
| stall_o | output | 1 | Pipeline stall enable |

## Verification
Every output is decoded from the state register in the same cycle. A wrong state therefore shows at the ports at the first sampling point after the faulty edge, as a wrong combination of stall, halted, sleeping and error flags. The timing of the debug stop path is checked to the exact edge, so a missing or extra synchroniser flop shows one cycle early or late. The bench also checks that a held stop level halts only once. Ignored inputs are checked by holding them active and confirming that the flags do not move.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_DRAIN    = 3'd1,
        ST_SLEEP    = 3'd2,
        ST_DBG_HALT = 3'd3,
        ST_ERR_HALT = 3'd4
    } hsc_state_e;
endpackage

// File: rtl/hsc_stop_edge.sv
module hsc_stop_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[LAST-1:0], async_i};
    end

    assign edge_o = sh_q[LAST-1] & ~sh_q[LAST];

    // R2: one pulse per rising level
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);
endmodule

// File: rtl/hsc_req.sv
module hsc_req #(
    parameter bit DEBUG_EN  = 1'b1,
    parameter bit FAULT_TOL = 1'b1,
    parameter int WAKE_W    = 2
) (
    input  logic              stop_edge_i,
    input  logic              halt_cmd_i,
    input  logic              resume_i,
    input  logic              brk_i,
    input  logic              nm_brk_i,
    input  logic              brk_mask_i,
    input  logic              miss_exc_i,
    input  logic [WAKE_W-1:0] wake_i,
    output logic              halt_req_o,
    output logic              halt_cmd_o,
    output logic              resume_o,
    output logic              fault_o,
    output logic              wake_any_o
);
    generate
        if (DEBUG_EN) begin : g_dbg
            assign halt_req_o = stop_edge_i | nm_brk_i | (brk_i & ~brk_mask_i);
            assign halt_cmd_o = halt_cmd_i;
            assign resume_o   = resume_i;
        end else begin : g_nodbg
            assign halt_req_o = 1'b0;
            assign halt_cmd_o = 1'b0;
            assign resume_o   = 1'b0;
        end
        if (FAULT_TOL) begin : g_ft
            assign fault_o = miss_exc_i;
        end else begin : g_noft
            assign fault_o = 1'b0;
        end
    endgenerate

    assign wake_any_o = |wake_i;
endmodule

// File: rtl/hsc_fsm.sv
module hsc_fsm
    import hsc_pkg::*;
#(
    parameter bit DEBUG_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_req_i,
    input  logic halt_cmd_i,
    input  logic resume_i,
    input  logic fault_i,
    input  logic wake_any_i,
    input  logic sleep_exec_i,
    input  logic ext_busy_i,
    input  logic pipe_drained_i,
    output logic halted_o,
    output logic sleeping_o,
    output logic err_halt_o,
    output logic dbg_wake_req_o,
    output logic stall_o
);
    hsc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fault_i)                        state_d = ST_ERR_HALT;
                else if (halt_req_i || halt_cmd_i)  state_d = ST_DBG_HALT;
                else if (sleep_exec_i)              state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (fault_i)                        state_d = ST_ERR_HALT;
                else if (halt_req_i || halt_cmd_i)  state_d = ST_DBG_HALT;
                else if (!ext_busy_i && pipe_drained_i) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (fault_i)                        state_d = ST_ERR_HALT;
                else if (halt_req_i)                state_d = ST_DBG_HALT;
                else if (wake_any_i)                state_d = ST_RUN;
            end
            ST_DBG_HALT: begin
                if (fault_i)                        state_d = ST_ERR_HALT;
                else if (resume_i)                  state_d = ST_RUN;
            end
            ST_ERR_HALT:                            state_d = ST_ERR_HALT;
            default:                                state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        halted_o       = (state_q == ST_DBG_HALT) || (state_q == ST_ERR_HALT);
        sleeping_o     = (state_q == ST_SLEEP);
        err_halt_o     = (state_q == ST_ERR_HALT);
        stall_o        = (state_q != ST_RUN);
        dbg_wake_req_o = (state_q == ST_SLEEP) && halt_cmd_i;
    end

    // R7: error halt is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERR_HALT) |=> (state_q == ST_ERR_HALT));
    // R5: sleep is never entered straight from run
    p_no_direct_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q != ST_SLEEP));
    // R5: draining holds while an access is outstanding
    p_drain_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && ext_busy_i && !fault_i && !halt_req_i && !halt_cmd_i)
        |=> (state_q == ST_DRAIN));
    // R10: sleeping implies stalled
    p_sleep_stalls_r10: assert property (@(posedge clk) disable iff (rst)
        sleeping_o |-> stall_o);
    // R6: wake does not leave the drain state
    p_wake_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && wake_any_i && ext_busy_i && !fault_i && !halt_req_i && !halt_cmd_i)
        |=> (state_q != ST_RUN));

    generate
        if (!DEBUG_EN) begin : g_chk_nodbg
            // R3: no debug halt without debug features
            p_no_dbg_halt_r3: assert property (@(posedge clk) disable iff (rst)
                state_q != ST_DBG_HALT);
        end
    endgenerate
endmodule

// File: rtl/halt_sleep_ctrl.sv
module halt_sleep_ctrl #(
    parameter bit DEBUG_EN    = 1'b1,
    parameter bit FAULT_TOL   = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_stop_i,
    input  logic              dbg_halt_cmd_i,
    input  logic              dbg_resume_i,
    input  logic              brk_i,
    input  logic              nm_brk_i,
    input  logic              brk_mask_i,
    input  logic              sleep_exec_i,
    input  logic              ext_busy_i,
    input  logic              pipe_drained_i,
    input  logic              miss_exc_i,
    input  logic [WAKE_W-1:0] wake_i,
    output logic              halted_o,
    output logic              sleeping_o,
    output logic              err_halt_o,
    output logic              dbg_wake_req_o,
    output logic              stall_o
);
    logic stop_edge;
    logic halt_req, halt_cmd, resume, fault, wake_any;

    generate
        if (DEBUG_EN) begin : g_sync
            hsc_stop_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk     (clk),
                .rst     (rst),
                .async_i (dbg_stop_i),
                .edge_o  (stop_edge)
            );
        end else begin : g_nosync
            assign stop_edge = 1'b0;
        end
    endgenerate

    hsc_req #(
        .DEBUG_EN  (DEBUG_EN),
        .FAULT_TOL (FAULT_TOL),
        .WAKE_W    (WAKE_W)
    ) u_req (
        .stop_edge_i (stop_edge),
        .halt_cmd_i  (dbg_halt_cmd_i),
        .resume_i    (dbg_resume_i),
        .brk_i       (brk_i),
        .nm_brk_i    (nm_brk_i),
        .brk_mask_i  (brk_mask_i),
        .miss_exc_i  (miss_exc_i),
        .wake_i      (wake_i),
        .halt_req_o  (halt_req),
        .halt_cmd_o  (halt_cmd),
        .resume_o    (resume),
        .fault_o     (fault),
        .wake_any_o  (wake_any)
    );

    hsc_fsm #(.DEBUG_EN(DEBUG_EN)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .halt_req_i     (halt_req),
        .halt_cmd_i     (halt_cmd),
        .resume_i       (resume),
        .fault_i        (fault),
        .wake_any_i     (wake_any),
        .sleep_exec_i   (sleep_exec_i),
        .ext_busy_i     (ext_busy_i),
        .pipe_drained_i (pipe_drained_i),
        .halted_o       (halted_o),
        .sleeping_o     (sleeping_o),
        .err_halt_o     (err_halt_o),
        .dbg_wake_req_o (dbg_wake_req_o),
        .stall_o        (stall_o)
    );

    // R8: a non-maskable break always leaves run
    p_nmbrk_halts_r8: assert property (@(posedge clk) disable iff (rst)
        (DEBUG_EN && nm_brk_i && !stall_o) |=> halted_o);
endmodule

// File: tb/sim_halt_sleep_ctrl.sv
module sim_halt_sleep_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_stop = 0, halt_cmd = 0, resume = 0, brk = 0, nm_brk = 0, mask = 0;
    logic sleep_exec = 0, ext_busy = 0, drained = 1, miss_exc = 0;
    logic [1:0] wake = 2'b00;
    logic [4:0] out0, out1;

    always #5 clk = ~clk;

    // output vector: {halted, sleeping, err_halt, dbg_wake_req, stall}
    halt_sleep_ctrl u0 (
        .clk(clk), .rst(rst), .dbg_stop_i(dbg_stop), .dbg_halt_cmd_i(halt_cmd),
        .dbg_resume_i(resume), .brk_i(brk), .nm_brk_i(nm_brk), .brk_mask_i(mask),
        .sleep_exec_i(sleep_exec), .ext_busy_i(ext_busy), .pipe_drained_i(drained),
        .miss_exc_i(miss_exc), .wake_i(wake),
        .halted_o(out0[4]), .sleeping_o(out0[3]), .err_halt_o(out0[2]),
        .dbg_wake_req_o(out0[1]), .stall_o(out0[0]));

    halt_sleep_ctrl #(.DEBUG_EN(1'b0), .FAULT_TOL(1'b0)) u1 (
        .clk(clk), .rst(rst), .dbg_stop_i(dbg_stop), .dbg_halt_cmd_i(halt_cmd),
        .dbg_resume_i(resume), .brk_i(brk), .nm_brk_i(nm_brk), .brk_mask_i(mask),
        .sleep_exec_i(sleep_exec), .ext_busy_i(ext_busy), .pipe_drained_i(drained),
        .miss_exc_i(miss_exc), .wake_i(wake),
        .halted_o(out1[4]), .sleeping_o(out1[3]), .err_halt_o(out1[2]),
        .dbg_wake_req_o(out1[1]), .stall_o(out1[0]));

    typedef struct {
        int         req;
        bit         sel;
        logic [4:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [4:0] O_RUN   = 5'b00000;
    localparam logic [4:0] O_DRAIN = 5'b00001;
    localparam logic [4:0] O_SLEEP = 5'b01001;
    localparam logic [4:0] O_SLWRQ = 5'b01011;
    localparam logic [4:0] O_DBG   = 5'b10001;
    localparam logic [4:0] O_ERR   = 5'b10101;

    // driver: let one edge pass, queue what the ports must show after it
    task automatic cyc(input int req, input bit sel, input logic [4:0] exp);
        item_t it;
        @(posedge clk);
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
        @(negedge clk);
        #2;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it = q.pop_front();
                act = it.sel ? out1 : out0;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL R%0d dut%0d actual %b expected %b", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R0 watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #2;
        cyc(1, 0, O_RUN);                      // R1 reset state
        rst = 0;
        cyc(1, 0, O_RUN);

        // R5 drain waits for accesses and pipeline
        ext_busy = 1; drained = 0; sleep_exec = 1;
        cyc(5, 0, O_DRAIN);
        sleep_exec = 0; wake = 2'b11;
        cyc(6, 0, O_DRAIN);                    // R6 wake ignored in drain
        wake = 2'b00; ext_busy = 0;
        cyc(5, 0, O_DRAIN);                    // R5 still not drained
        drained = 1;
        cyc(5, 0, O_SLEEP);
        wake = 2'b01;
        cyc(6, 0, O_RUN);                      // R6 wake from sleep
        wake = 2'b10;
        cyc(6, 0, O_RUN);                      // R6 wake ignored in run
        wake = 2'b00;

        // R2 synchronised edge-acting stop
        dbg_stop = 1;
        cyc(2, 0, O_RUN);
        cyc(2, 0, O_RUN);
        cyc(2, 0, O_DBG);
        cyc(2, 0, O_DBG);
        resume = 1;
        cyc(9, 0, O_RUN);                      // R9 resume
        resume = 0;
        cyc(2, 0, O_RUN);                      // R2 held level: no second halt
        cyc(2, 0, O_RUN);
        dbg_stop = 0;
        cyc(2, 0, O_RUN);
        cyc(2, 0, O_RUN);
        cyc(2, 0, O_RUN);

        // R8 maskable and non-maskable breaks
        mask = 1; brk = 1;
        cyc(8, 0, O_RUN);
        mask = 0;
        cyc(8, 0, O_DBG);
        brk = 0; resume = 1;
        cyc(9, 0, O_RUN);
        resume = 0; sleep_exec = 1;
        cyc(5, 0, O_DRAIN);
        sleep_exec = 0;
        cyc(5, 0, O_SLEEP);
        mask = 1; nm_brk = 1;
        cyc(8, 0, O_DBG);                      // R8 nm break leaves sleep
        nm_brk = 0; mask = 0; resume = 1;
        cyc(9, 0, O_RUN);
        resume = 0;

        // R4 halt command while sleeping asks for a wake
        sleep_exec = 1;
        cyc(5, 0, O_DRAIN);
        sleep_exec = 0;
        cyc(5, 0, O_SLEEP);
        halt_cmd = 1;
        cyc(4, 0, O_SLWRQ);
        wake = 2'b01;
        cyc(6, 0, O_RUN);
        wake = 2'b00;
        cyc(4, 0, O_DBG);
        halt_cmd = 0; resume = 1;
        cyc(9, 0, O_RUN);
        resume = 0;

        // R7 fault beats a break, error halt is sticky
        miss_exc = 1; nm_brk = 1;
        cyc(7, 0, O_ERR);
        miss_exc = 0; nm_brk = 0; resume = 1;
        cyc(7, 0, O_ERR);
        resume = 0; wake = 2'b11;
        cyc(7, 0, O_ERR);
        wake = 2'b00; rst = 1;
        cyc(1, 0, O_RUN);                      // R1 one-cycle reset
        rst = 0;

        // R3 / R7 on the variant without debug and fault features
        cyc(1, 1, O_RUN);
        dbg_stop = 1;
        cyc(3, 1, O_RUN);
        cyc(3, 1, O_RUN);
        cyc(3, 1, O_RUN);
        cyc(3, 1, O_RUN);
        halt_cmd = 1; nm_brk = 1; brk = 1;
        cyc(3, 1, O_RUN);
        halt_cmd = 0; nm_brk = 0; brk = 0; dbg_stop = 0; miss_exc = 1;
        cyc(7, 1, O_RUN);
        miss_exc = 0; sleep_exec = 1;
        cyc(5, 1, O_DRAIN);
        sleep_exec = 0; halt_cmd = 1;
        cyc(3, 1, O_SLEEP);                    // R3 no wake request either
        halt_cmd = 0; wake = 2'b10;
        cyc(6, 1, O_RUN);
        wake = 2'b00;

        @(negedge clk); #2;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule